// File: doc/BRIEF.md
# Iterative Degree-Domain Sine/Cosine Engine

This block returns the cosine and sine of one angle per request. It uses CORDIC rotation and performs one micro-rotation per clock. The angle arrives as a signed fixed-point number in degrees with 16 fractional bits. A one-cycle `start` captures it. The engine then brings the angle into the half-turn around zero by whole-turn steps, one step per cycle. It folds anything beyond a quarter turn back toward zero and notes that the result must change sign.

After that, a fixed number of rotations run from a pre-scaled starting vector. The starting vector already cancels the rotation gain, so the outputs come out with a unit amplitude close to 65536. The result is placed on registered outputs together with a one-cycle `done` pulse. The outputs keep their value until the next accepted request. A caller waits for `done`, or uses `busy` to know when a new `start` will be taken.

Top module: `cordic_sincos`

## Requirements
- R1: While `rst` is high, and after it is released, `busy` and `done` are 0 and both `cos_out` and `sin_out` read 0.
- R2: `angle` is signed, in degrees with 16 fractional bits (1 degree = 65536). The outputs are signed, with unit amplitude near 65536: 0 degrees gives `cos_out` within 200 of 65536, and 90 degrees gives `sin_out` within 200 of 65536.
- R3: An angle strictly above +180 degrees is reduced by 360 degrees, one step per cycle, until it is no longer above. An angle strictly below -180 degrees is raised by 360 degrees in the same way. Exactly ±180 degrees is left unchanged by this step.
- R4: After R3, an angle strictly above +90 degrees has 180 degrees subtracted, and one strictly below -90 degrees has 180 degrees added. In both of these cases the final outputs are negated (two's complement).
- R5: Each computation starts from x = 39797, y = 0 and accumulated angle 0, then applies 18 steps k = 0..17. Both updates in a step use the values from before that step, and the shifts are arithmetic. If the target is signed-greater than the accumulated angle, then x' = x - (y>>>k), y' = y + (x>>>k), and the accumulated angle gains table[k]. Otherwise x' = x + (y>>>k), y' = y - (x>>>k), and the accumulated angle loses table[k]. The table, in Q16 degrees, is 2949120, 1740967, 919879, 466945, 234379, 117304, 58666, 29335, 14668, 7334, 3667, 1833, 917, 458, 229, 115, 57, 29. `cos_out` carries x and `sin_out` carries y, with R4's negation applied.
- R6: `done` is high for exactly one cycle per accepted request. `cos_out` and `sin_out` change only on the cycle `done` rises, and they hold until the next result.
- R7: A `start` seen while `busy` is high is ignored. The running computation finishes with the angle captured first.
- R8: For |angle| <= 720 degrees, `done` rises no later than 23 clock edges after the edge that samples `start`. An angle already within ±180 degrees takes exactly 21 edges.
- R9: Results do not depend on earlier requests. Repeating an angle back to back gives identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures `angle` when idle |
| angle | input | 32 | Signed angle, degrees, 16 fractional bits |
| busy | output | 1 | High while a request is being processed |
| done | output | 1 | One-cycle result-valid pulse |
| cos_out | output | 32 | Signed cosine result, held until next result |
| sin_out | output | 32 | Signed sine result, held until next result |

## Verification
The angle set covers every quadrant, the exact fold points at ±90 and ±180 degrees, and angles that need zero, one or two whole-turn steps (up to ±720 degrees). Together these separate faults in wrapping, folding, output negation and rotation-direction choice. A fine-grained non-integer angle exercises the low table entries and the arithmetic shifts. Directed cases check the cycle on which `done` rises, that a `start` during `busy` is ignored, and that back-to-back repeats match.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int FRAC_BITS = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FOLD = 2'd1,
    ST_ROT  = 2'd2,
    ST_FIN  = 2'd3
  } cordic_state_e;

  // Arctangent of 2^-k in degrees, 16 fractional bits.
  function automatic int atan_deg_q16(input int k);
    case (k)
      0:  return 2949120;
      1:  return 1740967;
      2:  return 919879;
      3:  return 466945;
      4:  return 234379;
      5:  return 117304;
      6:  return 58666;
      7:  return 29335;
      8:  return 14668;
      9:  return 7334;
      10: return 3667;
      11: return 1833;
      12: return 917;
      13: return 458;
      14: return 229;
      15: return 115;
      16: return 57;
      17: return 29;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_range_fold.sv
module cordic_range_fold #(
  parameter int ANG_W  = 32,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [ANG_W-1:0] angle_in,
  output logic                    in_range,
  output logic signed [ANG_W-1:0] folded,
  output logic                    negate
);
  localparam logic signed [ANG_W-1:0] D90  = ANG_W'(90  * (1 << FRAC_W));
  localparam logic signed [ANG_W-1:0] D180 = ANG_W'(180 * (1 << FRAC_W));
  localparam logic signed [ANG_W-1:0] D360 = ANG_W'(360 * (1 << FRAC_W));

  logic signed [ANG_W-1:0] theta;
  logic                    above, below;

  assign above    = theta > D180;
  assign below    = theta < -D180;
  assign in_range = !above && !below;

  // One whole-turn step per cycle until the angle sits in [-180, +180].
  always_ff @(posedge clk) begin
    if (rst) begin
      theta <= '0;
    end else if (load) begin
      theta <= angle_in;
    end else if (above) begin
      theta <= theta - D360;
    end else if (below) begin
      theta <= theta + D360;
    end
  end

  // Quarter-turn fold with output sign flag.
  always_comb begin
    folded = theta;
    negate = 1'b0;
    if (theta > D90) begin
      folded = theta - D180;
      negate = 1'b1;
    end else if (theta < -D90) begin
      folded = theta + D180;
      negate = 1'b1;
    end
  end

endmodule

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot #(
  parameter int DAT_W = 32,
  parameter int ANG_W = 32,
  parameter int SH_W  = 5
) (
  input  logic signed [DAT_W-1:0] x_in,
  input  logic signed [DAT_W-1:0] y_in,
  input  logic signed [ANG_W-1:0] acc_in,
  input  logic signed [ANG_W-1:0] target,
  input  logic signed [ANG_W-1:0] step_ang,
  input  logic        [SH_W-1:0]  shift,
  output logic signed [DAT_W-1:0] x_out,
  output logic signed [DAT_W-1:0] y_out,
  output logic signed [ANG_W-1:0] acc_out
);
  logic signed [DAT_W-1:0] x_sh, y_sh;
  logic                    ccw;

  assign x_sh = x_in >>> shift;
  assign y_sh = y_in >>> shift;
  assign ccw  = target > acc_in;

  always_comb begin
    if (ccw) begin
      x_out   = x_in - y_sh;
      y_out   = y_in + x_sh;
      acc_out = acc_in + step_ang;
    end else begin
      x_out   = x_in + y_sh;
      y_out   = y_in - x_sh;
      acc_out = acc_in - step_ang;
    end
  end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int ANG_W  = 32,
  parameter int DAT_W  = 32,
  parameter int N_ITER = 18,
  parameter int INIT_X = 39797
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [ANG_W-1:0] angle,
  output logic                    busy,
  output logic                    done,
  output logic signed [DAT_W-1:0] cos_out,
  output logic signed [DAT_W-1:0] sin_out
);
  import cordic_pkg::*;

  localparam int CNT_W = (N_ITER > 1) ? $clog2(N_ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_ITER - 1);

  cordic_state_e state;

  logic signed [DAT_W-1:0] x_r, y_r, x_n, y_n;
  logic signed [ANG_W-1:0] acc_r, acc_n, tgt_r;
  logic                    neg_r;
  logic [CNT_W-1:0]        cnt;

  logic                    fold_ok, fold_neg;
  logic signed [ANG_W-1:0] fold_ang;
  logic signed [ANG_W-1:0] atan_rom [N_ITER];
  logic signed [ANG_W-1:0] atan_cur;

  genvar k;
  generate
    for (k = 0; k < N_ITER; k++) begin : g_atan
      assign atan_rom[k] = ANG_W'(atan_deg_q16(k));
    end
  endgenerate

  assign atan_cur = atan_rom[cnt];

  cordic_range_fold #(
    .ANG_W (ANG_W),
    .FRAC_W(FRAC_BITS)
  ) u_fold (
    .clk     (clk),
    .rst     (rst),
    .load    (state == ST_IDLE && start),
    .angle_in(angle),
    .in_range(fold_ok),
    .folded  (fold_ang),
    .negate  (fold_neg)
  );

  cordic_micro_rot #(
    .DAT_W(DAT_W),
    .ANG_W(ANG_W),
    .SH_W (CNT_W)
  ) u_rot (
    .x_in    (x_r),
    .y_in    (y_r),
    .acc_in  (acc_r),
    .target  (tgt_r),
    .step_ang(atan_cur),
    .shift   (cnt),
    .x_out   (x_n),
    .y_out   (y_n),
    .acc_out (acc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      x_r     <= '0;
      y_r     <= '0;
      acc_r   <= '0;
      tgt_r   <= '0;
      neg_r   <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      cos_out <= '0;
      sin_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_FOLD;
        end
        ST_FOLD: begin
          if (fold_ok) begin
            x_r   <= DAT_W'(INIT_X);
            y_r   <= '0;
            acc_r <= '0;
            tgt_r <= fold_ang;
            neg_r <= fold_neg;
            cnt   <= '0;
            state <= ST_ROT;
          end
        end
        ST_ROT: begin
          x_r   <= x_n;
          y_r   <= y_n;
          acc_r <= acc_n;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          cos_out <= neg_r ? -x_r : x_r;
          sin_out <= neg_r ? -y_r : y_r;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int DAT_W   = 32,
  parameter int N_ITER  = 18,
  parameter int LAT_MAX = 23
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic signed [DAT_W-1:0] cos_out,
  input logic signed [DAT_W-1:0] sin_out
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else run_len <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !busy && !done);  // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_OUT_HOLD_COS: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cos_out));  // R6
  AST_OUT_HOLD_SIN: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sin_out));  // R6
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));  // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));  // R6
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_len <= 8'(LAT_MAX));  // R8
  AST_OUT_MAG: assert property (@(posedge clk) disable iff (rst)
    done |-> (cos_out < 70000 && cos_out > -70000 &&
              sin_out < 70000 && sin_out > -70000));  // R2

endmodule

bind cordic_sincos cordic_sincos_chk #(
  .DAT_W  (DAT_W),
  .N_ITER (N_ITER),
  .LAT_MAX(N_ITER + 5)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .cos_out(cos_out),
  .sin_out(sin_out)
);

// File: tb/sim_cordic_sincos.sv
module sim_cordic_sincos;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [31:0] angle = '0;
  logic busy, done;
  logic signed [31:0] cos_out, sin_out;

  int total = 0;
  int bad = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  cordic_sincos u0 (
    .clk(clk), .rst(rst), .start(start), .angle(angle),
    .busy(busy), .done(done), .cos_out(cos_out), .sin_out(sin_out)
  );

  localparam int DEG = 65536;
  localparam int NV = 16;
  localparam int VEC [NV] = '{
    0, 30*DEG, 45*DEG, 90*DEG, -90*DEG, 135*DEG, -135*DEG, 180*DEG,
    -180*DEG, 270*DEG, -300*DEG, 720*DEG, -720*DEG, 91*DEG, -60*DEG, 1234567
  };

  function automatic int tab(input int k);
    int t [18] = '{2949120, 1740967, 919879, 466945, 234379, 117304, 58666,
                   29335, 14668, 7334, 3667, 1833, 917, 458, 229, 115, 57, 29};
    return t[k];
  endfunction

  task automatic model(input int a, output int ex, output int ey);
    int th = a;
    int x = 39797, y = 0, acc = 0, nx, ny;
    bit ng = 0;
    while (th > 180*DEG) th -= 360*DEG;
    while (th < -180*DEG) th += 360*DEG;
    if (th > 90*DEG) begin th -= 180*DEG; ng = 1; end
    else if (th < -90*DEG) begin th += 180*DEG; ng = 1; end
    for (int k = 0; k < 18; k++) begin
      if (th > acc) begin nx = x - (y >>> k); ny = y + (x >>> k); acc += tab(k); end
      else begin nx = x + (y >>> k); ny = y - (x >>> k); acc -= tab(k); end
      x = nx; y = ny;
    end
    ex = ng ? -x : x;
    ey = ng ? -y : y;
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive start at a negedge; wait for done; return edges counted.
  task automatic run(input int a, output int edges);
    edges = 0;
    @(negedge clk);
    angle = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 60) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    int ex, ey, ed, c1, s1;
    repeat (3) @(negedge clk);
    check("R1 busy", busy == 0, busy, 0);
    check("R1 done", done == 0, done, 0);
    check("R1 cos", cos_out == 0, cos_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after release", !busy && !done && sin_out == 0, sin_out, 0);

    // Vector table: R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      run(VEC[v], ed);
      model(VEC[v], ex, ey);
      check("R5 cos", cos_out == ex, cos_out, ex);
      check("R5 sin", sin_out == ey, sin_out, ey);
      check("R8 latency", ed <= 23 && done, ed, 23);
    end

    // R2 scale
    run(0, ed);
    check("R2 cos0", cos_out > 65336 && cos_out < 65736, cos_out, 65536);
    check("R8 exact latency in range", ed == 21, ed, 21);
    run(90*DEG, ed);
    check("R2 sin90", sin_out > 65336 && sin_out < 65736, sin_out, 65536);

    // R3/R4 wrap and fold equivalence
    run(200*DEG, ed); c1 = cos_out; s1 = sin_out;
    run(-160*DEG, ed);
    check("R3 wrap 200 vs -160", cos_out == c1 && sin_out == s1, cos_out, c1);
    run(120*DEG, ed); model(-60*DEG, ex, ey);
    check("R4 fold negate cos", cos_out == -ex, cos_out, -ex);
    check("R4 fold negate sin", sin_out == -ey, sin_out, -ey);

    // R6 one-cycle done, hold
    run(30*DEG, ed); c1 = cos_out;
    @(negedge clk);
    check("R6 done pulse", done == 0, done, 0);
    repeat (5) @(negedge clk);
    check("R6 hold", cos_out == c1, cos_out, c1);

    // R7 start during busy ignored
    @(negedge clk);
    angle = 45*DEG; start = 1'b1;
    @(negedge clk);
    angle = -170*DEG;
    repeat (4) @(negedge clk);
    start = 1'b0;
    ed = 0;
    while (!done && ed < 60) begin @(negedge clk); ed++; end
    model(45*DEG, ex, ey);
    check("R7 ignored start cos", cos_out == ex, cos_out, ex);
    check("R7 ignored start sin", sin_out == ey, sin_out, ey);

    // R9 repeat
    run(1234567, ed); c1 = cos_out; s1 = sin_out;
    run(1234567, ed);
    check("R9 repeat", cos_out == c1 && sin_out == s1, cos_out, c1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule